// File: doc/BRIEF.md
# Write-Protected Extended Configuration Register Bank

This block gives a processor I/O-mapped access to a bank of 64 eight-bit extended configuration registers for a display controller. It decodes three ports. The guard port holds an unlock flag and two feature enables. The pointer port selects a bank entry. The value port reads and writes the selected entry. While the unlock flag is clear, every write through the pointer and value ports is dropped. This protects the configuration from software that does not know the controller is there.

Reads of the guard port return a fixed signature byte unless a bit in the bank enables true readback. Identification software uses this signature. A 16-bit write to the pointer port loads the pointer and the selected entry in one access. The whole bank is exported in flat form to the rest of the display logic. A sticky halt flag marks the fault state that a particular bank bit requests.

Top module: `extRegPort`

## Requirements
- R1: A write to the guard port (0x3DF) is always accepted and stores the low data byte. Guard bit 0 drives `monoGfxEn`, guard bit 1 drives `pageHighEn`, and guard bit 7 is the unlock flag.
- R2: While guard bit 7 is clear, byte and word writes to the pointer port (0x3DD) and byte writes to the value port (0x3DE) change neither the pointer nor any bank entry.
- R3: A byte write to the pointer port while unlocked sets the pointer to data bits 5:0 and ignores bits 7:6. A byte write to the value port while unlocked stores the data byte in the entry selected by the pointer.
- R4: A word write (`wrWide` high) to the pointer port while unlocked sets the pointer to bits 5:0 and stores bits 15:8 into that entry in the same cycle. At the guard and value ports a word write acts as a byte write of bits 7:0.
- R5: Reading the guard port returns 0xC1 while bit 6 of bank entry 0x29 is clear, and the stored guard byte while that bit is set.
- R6: Reading the value port returns the selected entry, and reading the pointer port returns the pointer zero-extended. `rdData` changes in the cycle after the `rdStrobe` pulse and holds otherwise.
- R7: After reset, every bank entry, the guard byte, the pointer, the halt flag and `rdData` are zero.
- R8: Once bit 7 of bank entry 0x29 has held a 1, `haltFlag` is set in the same clock edge and stays set until reset, even if that bit is later cleared.
- R9: `regBankFlat` bits [8i+7:8i] always equal bank entry i.
- R10: Writes to any other port address change nothing, and reads from them return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portAddr | input | 10 | I/O port address |
| wrStrobe | input | 1 | One-cycle write strobe |
| wrWide | input | 1 | Marks the write as a 16-bit access |
| rdStrobe | input | 1 | One-cycle read strobe |
| wrData | input | 16 | Write data; low byte for byte writes |
| rdData | output | 8 | Read data, registered |
| monoGfxEn | output | 1 | Guard bit 0 |
| pageHighEn | output | 1 | Guard bit 1 |
| haltFlag | output | 1 | Sticky fault flag |
| regBankFlat | output | 512 | All 64 bank entries, entry i at [8i+7:8i] |

## Verification
The bench sweeps every pointer value through both the byte path and the word path, with the upper pointer bits set. A decoder that used those bits, or a word write that took the old pointer, would leave entries in the wrong place. Writes are attempted while locked. A gate that missed the word path would corrupt the bank. The identification sequence and both states of the readback bit are exercised. A design that returned the stored byte without the gate would fail identification. The halt test clears the fault bit after setting it, which catches a flag that merely follows the bit.

// File: rtl/extreg_pkg.sv
package extreg_pkg;
  typedef struct packed {
    logic protectWr;
    logic indexWr;
    logic wideWr;
    logic dataWr;
    logic rdProt;
    logic rdIdx;
    logic rdReg;
    logic rdNone;
  } regStrobe_t;
endpackage

// File: rtl/extRegCtrl.sv
module extRegCtrl
  import extreg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter logic [ADDR_W-1:0] PROTECT_ADDR = 10'h3DF,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 10'h3DD,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 10'h3DE
) (
  input  logic [ADDR_W-1:0] portAddr,
  input  logic              wrStrobe,
  input  logic              wrWide,
  input  logic              rdStrobe,
  input  logic              unlocked,
  output regStrobe_t        strobe
);
  logic hitProt, hitIdx, hitReg, hitAny;

  assign hitProt = (portAddr == PROTECT_ADDR);
  assign hitIdx  = (portAddr == INDEX_ADDR);
  assign hitReg  = (portAddr == DATA_ADDR);
  assign hitAny  = hitProt | hitIdx | hitReg;

  always_comb begin
    strobe           = '0;
    strobe.protectWr = wrStrobe & hitProt;
    strobe.indexWr   = wrStrobe & hitIdx & unlocked & ~wrWide;
    strobe.wideWr    = wrStrobe & hitIdx & unlocked & wrWide;
    strobe.dataWr    = wrStrobe & hitReg & unlocked;
    strobe.rdProt    = rdStrobe & hitProt;
    strobe.rdIdx     = rdStrobe & hitIdx;
    strobe.rdReg     = rdStrobe & hitReg;
    strobe.rdNone    = rdStrobe & ~hitAny;
  end
endmodule

// File: rtl/extRegDatapath.sv
module extRegDatapath
  import extreg_pkg::*;
#(
  parameter int IDX_W = 6,
  parameter int DATA_W = 8,
  parameter int unsigned CFG_IDX = 'h29,
  parameter int READ_EN_BIT = 6,
  parameter int HALT_BIT = 7,
  parameter int UNLOCK_BIT = 7,
  parameter int MONO_BIT = 0,
  parameter int PAGE_BIT = 1,
  parameter logic [DATA_W-1:0] SIG_VALUE = 8'hC1,
  localparam int DEPTH = 1 << IDX_W,
  localparam int BUS_W = 2 * DATA_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrobe_t              strobe,
  input  logic [BUS_W-1:0]        wrData,
  output logic [DATA_W-1:0]       rdData,
  output logic                    unlocked,
  output logic                    monoGfxEn,
  output logic                    pageHighEn,
  output logic                    haltFlag,
  output logic [DEPTH*DATA_W-1:0] regBankFlat
);
  logic [DATA_W-1:0] bank [DEPTH];
  logic [DATA_W-1:0] protectQ;
  logic [IDX_W-1:0]  indexQ;
  logic              haltQ;
  logic [DATA_W-1:0] rdQ, rdNext;
  logic              bankWrEn;
  logic [IDX_W-1:0]  bankWrIdx;
  logic [DATA_W-1:0] bankWrVal;
  logic [DATA_W-1:0] cfgEntry;

  assign bankWrEn  = strobe.dataWr | strobe.wideWr;
  assign bankWrIdx = strobe.wideWr ? wrData[IDX_W-1:0] : indexQ;
  assign bankWrVal = strobe.wideWr ? wrData[BUS_W-1:DATA_W] : wrData[DATA_W-1:0];
  assign cfgEntry  = bank[CFG_IDX];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      protectQ <= '0;
      indexQ   <= '0;
    end else begin
      if (strobe.protectWr) protectQ <= wrData[DATA_W-1:0];
      if (strobe.indexWr || strobe.wideWr) indexQ <= wrData[IDX_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) bank[i] <= '0;
    end else if (bankWrEn) begin
      bank[bankWrIdx] <= bankWrVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) haltQ <= 1'b0;
    else if (bankWrEn && bankWrIdx == IDX_W'(CFG_IDX) && bankWrVal[HALT_BIT])
      haltQ <= 1'b1;
  end

  always_comb begin
    if (strobe.rdProt)
      rdNext = cfgEntry[READ_EN_BIT] ? protectQ : SIG_VALUE;
    else if (strobe.rdIdx)
      rdNext = DATA_W'(indexQ);
    else if (strobe.rdReg)
      rdNext = bank[indexQ];
    else
      rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdQ <= '0;
    else if (strobe.rdProt || strobe.rdIdx || strobe.rdReg || strobe.rdNone)
      rdQ <= rdNext;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_flat
    assign regBankFlat[g*DATA_W +: DATA_W] = bank[g];
  end

  assign rdData     = rdQ;
  assign unlocked   = protectQ[UNLOCK_BIT];
  assign monoGfxEn  = protectQ[MONO_BIT];
  assign pageHighEn = protectQ[PAGE_BIT];
  assign haltFlag   = haltQ;

  assert_locked_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !protectQ[UNLOCK_BIT] |=> ($stable(regBankFlat) && $stable(indexQ)));

  assert_guard_store_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.protectWr |=> (protectQ == $past(wrData[DATA_W-1:0])));

  assert_signature_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.rdProt && !cfgEntry[READ_EN_BIT]) |=> (rdData == SIG_VALUE));

  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    haltQ |=> haltQ);

  assert_halt_cover_R8: assert property (@(posedge clk) disable iff (!rstN)
    cfgEntry[HALT_BIT] |-> haltQ);

  assert_one_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.protectWr, strobe.indexWr, strobe.wideWr, strobe.dataWr}));

  assert_read_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.rdProt || strobe.rdIdx || strobe.rdReg || strobe.rdNone) |=> $stable(rdData));
endmodule

// File: rtl/extRegPort.sv
module extRegPort
  import extreg_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W = 6,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] PROTECT_ADDR = 10'h3DF,
  parameter logic [ADDR_W-1:0] INDEX_ADDR = 10'h3DD,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 10'h3DE,
  localparam int DEPTH = 1 << IDX_W,
  localparam int BUS_W = 2 * DATA_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [ADDR_W-1:0]       portAddr,
  input  logic                    wrStrobe,
  input  logic                    wrWide,
  input  logic                    rdStrobe,
  input  logic [BUS_W-1:0]        wrData,
  output logic [DATA_W-1:0]       rdData,
  output logic                    monoGfxEn,
  output logic                    pageHighEn,
  output logic                    haltFlag,
  output logic [DEPTH*DATA_W-1:0] regBankFlat
);
  regStrobe_t strobe;
  logic       unlocked;

  extRegCtrl #(
    .ADDR_W(ADDR_W), .PROTECT_ADDR(PROTECT_ADDR),
    .INDEX_ADDR(INDEX_ADDR), .DATA_ADDR(DATA_ADDR)
  ) u_ctrl (
    .portAddr(portAddr), .wrStrobe(wrStrobe), .wrWide(wrWide),
    .rdStrobe(rdStrobe), .unlocked(unlocked), .strobe(strobe)
  );

  extRegDatapath #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .rdData(rdData), .unlocked(unlocked), .monoGfxEn(monoGfxEn),
    .pageHighEn(pageHighEn), .haltFlag(haltFlag), .regBankFlat(regBankFlat)
  );
endmodule

// File: tb/extRegPort_bench.sv
module extRegPort_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [9:0] P_GUARD = 10'h3DF;
  localparam logic [9:0] P_IDX = 10'h3DD;
  localparam logic [9:0] P_VAL = 10'h3DE;
  localparam logic [9:0] P_OTHER = 10'h3D0;

  logic clk = 0, rstN = 0;
  logic [9:0] portAddr = '0;
  logic wrStrobe = 0, wrWide = 0, rdStrobe = 0;
  logic [15:0] wrData = '0;
  logic [7:0] rdData;
  logic monoGfxEn, pageHighEn, haltFlag;
  logic [511:0] regBankFlat;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] mBank [64];
  logic [7:0] mGuard;
  logic [5:0] mIdx;
  logic mHalt;

  always #(CLK_PERIOD/2) clk = ~clk;

  extRegPort u_extRegPort (
    .clk(clk), .rstN(rstN), .portAddr(portAddr), .wrStrobe(wrStrobe),
    .wrWide(wrWide), .rdStrobe(rdStrobe), .wrData(wrData), .rdData(rdData),
    .monoGfxEn(monoGfxEn), .pageHighEn(pageHighEn), .haltFlag(haltFlag),
    .regBankFlat(regBankFlat)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic modelReset();
    for (int i = 0; i < 64; i++) mBank[i] = 8'h00;
    mGuard = 8'h00; mIdx = 6'd0; mHalt = 1'b0;
  endtask

  task automatic doWrite(input logic [9:0] a, input logic [15:0] d, input logic wide);
    @(negedge clk);
    portAddr = a; wrData = d; wrWide = wide; wrStrobe = 1'b1;
    @(negedge clk);
    wrStrobe = 1'b0; wrWide = 1'b0;
    if (a == P_GUARD) mGuard = d[7:0];
    else if (a == P_IDX && mGuard[7]) begin
      mIdx = d[5:0];
      if (wide) mBank[d[5:0]] = d[15:8];
    end else if (a == P_VAL && mGuard[7]) mBank[mIdx] = d[7:0];
    if (mBank[6'h29][7]) mHalt = 1'b1;
  endtask

  task automatic doRead(input logic [9:0] a, output logic [7:0] v);
    @(negedge clk);
    portAddr = a; rdStrobe = 1'b1;
    @(negedge clk);
    rdStrobe = 1'b0;
    v = rdData;
  endtask

  function automatic logic [7:0] expGuard();
    return mBank[6'h29][6] ? mGuard : 8'hC1;
  endfunction

  task automatic checkBank(input string req);
    int bad = 0;
    for (int i = 0; i < 64; i++)
      if (regBankFlat[i*8 +: 8] !== mBank[i]) bad++;
    check(req, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, hold;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 rdData", rdData, 0);
    check("R7 halt", haltFlag, 0);
    check("R7 features", {monoGfxEn, pageHighEn}, 0);
    checkBank("R7 bank");

    // R2 locked writes are dropped
    doWrite(P_IDX, 16'h0005, 1'b0);
    doWrite(P_VAL, 16'h0055, 1'b0);
    doWrite(P_IDX, 16'hAA07, 1'b1);
    checkBank("R2 locked bank");
    doRead(P_IDX, v); check("R2 locked pointer", v, 0);
    doRead(P_GUARD, v); check("R5 signature locked", v, 8'hC1);

    // R1 guard bits
    doWrite(P_GUARD, 16'h0083, 1'b0);
    check("R1 mono", monoGfxEn, 1);
    check("R1 page", pageHighEn, 1);
    doRead(P_GUARD, v); check("R5 signature unlocked", v, 8'hC1);

    // R3/R6/R9 byte sweep with upper pointer bits set
    for (int i = 0; i < 64; i++) begin
      logic [7:0] val;
      val = 8'((i * 37 + 11) & 255);
      if (i == 'h29) val = val & 8'h3F;
      doWrite(P_IDX, 16'(i | ((i % 4) << 6)), 1'b0);
      doWrite(P_VAL, {8'hEE, val}, 1'b0);
      doRead(P_VAL, v); check("R3/R6 byte readback", v, val);
      doRead(P_IDX, v); check("R6 pointer readback", v, 8'(i));
      check("R9 slice", regBankFlat[i*8 +: 8], val);
    end
    checkBank("R9 after byte sweep");

    // R4 word sweep
    for (int i = 63; i >= 0; i--) begin
      logic [7:0] val;
      val = 8'((i * 91 + 200) & 255);
      if (i == 'h29) val = val & 8'h3F;
      doWrite(P_IDX, {val, 8'(i | 8'hC0)}, 1'b1);
      check("R4 word slice", regBankFlat[i*8 +: 8], val);
      doRead(P_VAL, v); check("R4 word pointer", v, val);
    end
    checkBank("R4 after word sweep");

    // R4 word write at value port acts on low byte
    doWrite(P_IDX, 16'h0010, 1'b0);
    doWrite(P_VAL, 16'h7733, 1'b1);
    check("R4 wide at value port", regBankFlat[16*8 +: 8], 8'h33);

    // R6 read hold
    doRead(P_VAL, hold);
    repeat (4) @(negedge clk);
    check("R6 hold", rdData, hold);

    // R2 relock
    doWrite(P_GUARD, 16'h0000, 1'b0);
    check("R1 mono cleared", monoGfxEn, 0);
    doWrite(P_VAL, 16'h00FF, 1'b0);
    doWrite(P_IDX, 16'h9902, 1'b1);
    doWrite(P_IDX, 16'h0003, 1'b0);
    checkBank("R2 relocked bank");
    doRead(P_IDX, v); check("R2 relocked pointer", v, 8'h10);

    // R5 true readback
    doWrite(P_GUARD, 16'h0081, 1'b0);
    doWrite(P_IDX, 16'h4029, 1'b1);
    doRead(P_GUARD, v); check("R5 true readback", v, 8'h81);

    // R10 other port
    doWrite(P_OTHER, 16'h00AB, 1'b0);
    checkBank("R10 other write");
    doRead(P_OTHER, v); check("R10 other read", v, 0);

    // R5 identification sequence
    doWrite(P_GUARD, 16'h0080, 1'b0);
    doWrite(P_IDX, 16'h0029, 1'b0);
    doWrite(P_VAL, 16'h0020, 1'b0);
    doRead(P_GUARD, v); check("R5 identification", v, expGuard());
    check("R5 identification const", v, 8'hC1);

    // R8 sticky halt
    check("R8 halt before", haltFlag, 0);
    doWrite(P_VAL, 16'h00C0, 1'b0);
    check("R8 halt set", haltFlag, 1);
    doWrite(P_VAL, 16'h0000, 1'b0);
    check("R8 halt sticky", haltFlag, mHalt);
    check("R8 halt sticky const", haltFlag, 1);

    // R7 second reset
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    modelReset();
    @(negedge clk);
    checkBank("R7 bank after reset");
    check("R7 halt after reset", haltFlag, 0);
    check("R7 rdData after reset", rdData, 0);
    doRead(P_IDX, v); check("R7 pointer after reset", v, 0);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule